// File: doc/BRIEF.md
# Auto-Shutdown Successive-Approximation Converter Interface

This block is a synthesizable model of the digital side of a small two-input sampling converter that switches itself off between conversions. The analog sample is stood in for by two 10-bit codes on input ports. A host drives a conversion-start line and a serial clock. The block reads the start pulse pattern to pick the input or polarity, times the conversion with an internal divided clock, and then shifts a 12-bit frame out on a data line with a separate output-enable.

A single high pulse on the start line selects input A, or unipolar mode in the differential variant. A high–low–high pattern selects input B, or bipolar mode. The low gap in that pattern must close within `GAP_CYC` system clocks of the first falling edge. If the host did not clock out the whole previous frame before raising start again, the next conversion uses input B or bipolar mode no matter what pulse follows. Both asynchronous host lines pass through synchronizers into the system clock domain.

The state machine has six states:
- `ST_SHDN`: asleep, line released.
- `ST_TRACK`: acquiring after a start rise.
- `ST_HOLD`: converting input A, with the double-pulse window still open.
- `ST_TRACK_B`: acquiring after a second start rise.
- `ST_CONV`: converting, with no retrigger possible.
- `ST_READ`: frame being shifted out.

Transitions:
- `ST_SHDN` to `ST_TRACK` on a start rise.
- `ST_TRACK` to `ST_HOLD` on a start fall, or to `ST_CONV` if input B was already forced.
- `ST_HOLD` to `ST_TRACK_B` on a start rise while the window is open.
- `ST_HOLD` to `ST_READ` when the timer completes.
- `ST_TRACK_B` to `ST_CONV` on a start fall.
- `ST_CONV` to `ST_READ` when the timer completes.
- `ST_READ` to `ST_SHDN` after the twelfth serial rise.
- `ST_READ` to `ST_TRACK` on an early start rise. This is a partial read, and it forces input B.

Top module: `autoshdn_sar_if`

## Requirements
- R1: After reset, and after a complete frame has been read, `dout_oe_o` is 0 and `busy_o` is 0.
- R2: A start rise seen in shutdown, or during a read, drives `dout_oe_o`=1 and `dout_o`=0 within 6 system clocks.
- R3: A single start pulse selects input A. In the differential variant it selects unipolar mode.
- R4: A start fall followed by a rise within `GAP_CYC` clocks selects input B. In the differential variant it selects bipolar mode. A low gap longer than `GAP_CYC` leaves input A selected.
- R5: `busy_o` is 1 from the conversion's start fall until the MSB is driven. It falls no later than `CLK_DIV*CONV_TICKS`+8 clocks after that fall, and not before `CLK_DIV*CONV_TICKS`-8 clocks.
- R6: The frame is the 10 result bits MSB first, followed by two sub-bits that are both 0. `dout_o` changes only after a serial-clock falling edge, never on a rise.
- R7: After the twelfth serial-clock rise of a frame, `dout_oe_o` goes to 0.
- R8: If start rises before twelve bits have been read, the next conversion uses input B, or bipolar mode in the differential variant.
- R9: The sample is latched at the start fall that begins conversion. The encodings are:
  - Single-ended variant: straight binary of the selected input.
  - Differential unipolar: A−B, clamped at 0.
  - Differential bipolar: A−B as 10-bit two's complement, clamped to −512..511.
- R10: Start edges after the double-pulse window has closed, while converting, have no effect on the result or on `busy_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Asynchronous conversion-start line |
| sclk_i | input | 1 | Asynchronous serial clock from the host |
| sample_a_i | input | 10 | Digital stand-in for input A (positive input) |
| sample_b_i | input | 10 | Digital stand-in for input B (negative input) |
| dout_o | output | 1 | Serial data bit |
| dout_oe_o | output | 1 | Output enable for the data pad; 0 means high-impedance |
| busy_o | output | 1 | Conversion in progress |

## Verification
Each start pattern is tried in turn:
- A single pulse.
- A double pulse with a 40 ns gap.
- A pulse whose low time overruns the window, followed by a stray high pulse during conversion.
- A pulse issued right after a frame that was read only partly.

Single-ended and differential instances run side by side on the same stimulus. This separates input selection from polarity encoding. Code pairs cover full scale, zero, negative differences that clamp and in-range bipolar values. The sample inputs are scrambled right after hold, which shows whether the value was latched at the correct edge. Every frame bit is sampled both before and after each serial rise, which separates updates on the falling edge from updates on the rising edge.

// File: rtl/autoshdn_sar_pkg.sv
package autoshdn_sar_pkg;

    typedef enum logic [2:0] {
        ST_SHDN,
        ST_TRACK,
        ST_HOLD,
        ST_TRACK_B,
        ST_CONV,
        ST_READ
    } sar_state_e;

    localparam int SUB_BITS = 2;

endpackage

// File: rtl/autoshdn_edge_sync.sv
module autoshdn_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], async_i};
        end
    end

    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall_o = ~chain_q[STAGES-1] & chain_q[STAGES];

endmodule

// File: rtl/autoshdn_conv_timer.sv
module autoshdn_conv_timer #(
    parameter int CLK_DIV    = 63,
    parameter int CONV_TICKS = 14,
    parameter int GAP_CYC    = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic run_i,
    output logic window_o,
    output logic done_o
);
    localparam int DIV_W = $clog2(CLK_DIV);
    localparam int TK_W  = $clog2(CONV_TICKS);
    localparam int GAP_W = $clog2(GAP_CYC + 1);
    localparam logic [DIV_W-1:0] DIV_LAST  = DIV_W'(CLK_DIV - 1);
    localparam logic [TK_W-1:0]  TICK_LAST = TK_W'(CONV_TICKS - 1);
    localparam logic [GAP_W-1:0] GAP_END   = GAP_W'(GAP_CYC);

    logic [DIV_W-1:0] div_q;
    logic [TK_W-1:0]  tick_q;
    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            tick_q <= '0;
            gap_q  <= '0;
        end else if (start_i) begin
            div_q  <= '0;
            tick_q <= '0;
            gap_q  <= '0;
        end else if (run_i) begin
            if (gap_q != GAP_END) begin
                gap_q <= gap_q + 1'b1;
            end
            if (div_q == DIV_LAST) begin
                div_q <= '0;
                if (tick_q != TICK_LAST) begin
                    tick_q <= tick_q + 1'b1;
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign window_o = (gap_q != GAP_END);
    assign done_o   = run_i && (div_q == DIV_LAST) && (tick_q == TICK_LAST);

    AST_WINDOW_SHUTS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !window_o); // R4

endmodule

// File: rtl/autoshdn_result_fmt.sv
module autoshdn_result_fmt #(
    parameter int DATA_W     = 10,
    parameter int DIFF_INPUT = 0
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              alt_i,
    output logic [DATA_W-1:0] result_o
);
    generate
        if (DIFF_INPUT == 0) begin : g_single
            assign result_o = alt_i ? b_i : a_i;
        end else begin : g_diff
            localparam logic signed [DATA_W:0] POS_MAX = (DATA_W+1)'((2 ** (DATA_W - 1)) - 1);
            localparam logic signed [DATA_W:0] NEG_MIN = -(DATA_W+1)'(2 ** (DATA_W - 1));
            logic signed [DATA_W:0] diff;
            assign diff = $signed({1'b0, a_i}) - $signed({1'b0, b_i});
            always_comb begin
                if (!alt_i) begin
                    result_o = diff[DATA_W] ? '0 : diff[DATA_W-1:0];
                end else if (diff > POS_MAX) begin
                    result_o = POS_MAX[DATA_W-1:0];
                end else if (diff < NEG_MIN) begin
                    result_o = NEG_MIN[DATA_W-1:0];
                end else begin
                    result_o = diff[DATA_W-1:0];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/autoshdn_frame_shift.sv
module autoshdn_frame_shift #(
    parameter int DATA_W = 10,
    parameter int SUB_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              active_i,
    input  logic              sclk_rise_i,
    input  logic              sclk_fall_i,
    output logic              bit_o,
    output logic              done_o
);
    localparam int FRAME_W = DATA_W + SUB_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST_RISE = CNT_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] frame_q;
    logic [CNT_W-1:0]   rcnt_q;
    logic               pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '0;
            rcnt_q  <= '0;
            pend_q  <= 1'b0;
        end else if (load_i) begin
            frame_q <= {data_i, {SUB_W{1'b0}}};
            rcnt_q  <= '0;
            pend_q  <= 1'b0;
        end else if (active_i) begin
            if (sclk_rise_i) begin
                rcnt_q <= rcnt_q + 1'b1;
                pend_q <= 1'b1;
            end else if (sclk_fall_i && pend_q) begin
                frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
                pend_q  <= 1'b0;
            end
        end
    end

    assign bit_o  = frame_q[FRAME_W-1];
    assign done_o = active_i && sclk_rise_i && (rcnt_q == LAST_RISE);

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        active_i |-> (rcnt_q <= LAST_RISE)); // R7
    AST_SHIFT_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !load_i && !sclk_fall_i) |=> $stable(frame_q)); // R6

endmodule

// File: rtl/autoshdn_sar_if.sv
module autoshdn_sar_if
    import autoshdn_sar_pkg::*;
#(
    parameter int DATA_W      = 10,
    parameter int CLK_DIV     = 63,
    parameter int CONV_TICKS  = 14,
    parameter int GAP_CYC     = 32,
    parameter int SYNC_STAGES = 2,
    parameter int DIFF_INPUT  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              sclk_i,
    input  logic [DATA_W-1:0] sample_a_i,
    input  logic [DATA_W-1:0] sample_b_i,
    output logic              dout_o,
    output logic              dout_oe_o,
    output logic              busy_o
);
    sar_state_e state_q, state_d;
    logic alt_q, alt_d;
    logic [DATA_W-1:0] samp_a_q, samp_b_q;
    logic [DATA_W-1:0] result_w;
    logic start_rise, start_fall, sclk_rise, sclk_fall;
    logic tmr_start, tmr_run, tmr_window, tmr_done;
    logic shift_load, shift_bit, shift_done, reading;
    logic latch_now;

    autoshdn_edge_sync #(.STAGES(SYNC_STAGES)) u_start_sync (
        .clk(clk), .rst_n(rst_n), .async_i(start_i),
        .rise_o(start_rise), .fall_o(start_fall)
    );

    autoshdn_edge_sync #(.STAGES(SYNC_STAGES)) u_sclk_sync (
        .clk(clk), .rst_n(rst_n), .async_i(sclk_i),
        .rise_o(sclk_rise), .fall_o(sclk_fall)
    );

    assign latch_now = start_fall && (state_q == ST_TRACK || state_q == ST_TRACK_B);
    assign tmr_start = latch_now;
    assign tmr_run   = (state_q == ST_HOLD) || (state_q == ST_CONV);

    autoshdn_conv_timer #(
        .CLK_DIV(CLK_DIV), .CONV_TICKS(CONV_TICKS), .GAP_CYC(GAP_CYC)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .start_i(tmr_start), .run_i(tmr_run),
        .window_o(tmr_window), .done_o(tmr_done)
    );

    autoshdn_result_fmt #(.DATA_W(DATA_W), .DIFF_INPUT(DIFF_INPUT)) u_fmt (
        .a_i(samp_a_q), .b_i(samp_b_q), .alt_i(alt_q), .result_o(result_w)
    );

    assign shift_load = tmr_done;
    assign reading    = (state_q == ST_READ);

    autoshdn_frame_shift #(.DATA_W(DATA_W), .SUB_W(SUB_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n), .load_i(shift_load), .data_i(result_w),
        .active_i(reading), .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall),
        .bit_o(shift_bit), .done_o(shift_done)
    );

    // next-state decode
    always_comb begin
        state_d = state_q;
        alt_d   = alt_q;
        unique case (state_q)
            ST_SHDN: begin
                if (start_rise) begin
                    state_d = ST_TRACK;
                    alt_d   = 1'b0;
                end
            end
            ST_TRACK: begin
                if (start_fall) begin
                    state_d = alt_q ? ST_CONV : ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (tmr_done) begin
                    state_d = ST_READ;
                end else if (start_rise && tmr_window) begin
                    state_d = ST_TRACK_B;
                    alt_d   = 1'b1;
                end
            end
            ST_TRACK_B: begin
                if (start_fall) begin
                    state_d = ST_CONV;
                end
            end
            ST_CONV: begin
                if (tmr_done) begin
                    state_d = ST_READ;
                end
            end
            ST_READ: begin
                if (start_rise) begin
                    state_d = ST_TRACK;
                    alt_d   = ~shift_done;
                end else if (shift_done) begin
                    state_d = ST_SHDN;
                end
            end
            default: begin
                state_d = ST_SHDN;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_SHDN;
            alt_q    <= 1'b0;
            samp_a_q <= '0;
            samp_b_q <= '0;
        end else begin
            state_q <= state_d;
            alt_q   <= alt_d;
            if (latch_now) begin
                samp_a_q <= sample_a_i;
                samp_b_q <= sample_b_i;
            end
        end
    end

    // outputs
    always_comb begin
        dout_oe_o = 1'b1;
        dout_o    = 1'b0;
        busy_o    = 1'b0;
        unique case (state_q)
            ST_SHDN:    dout_oe_o = 1'b0;
            ST_TRACK:   dout_o    = 1'b0;
            ST_TRACK_B: dout_o    = 1'b0;
            ST_HOLD:    busy_o    = 1'b1;
            ST_CONV:    busy_o    = 1'b1;
            ST_READ:    dout_o    = shift_bit;
            default:    dout_oe_o = 1'b0;
        endcase
    end

    AST_WAKE_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHDN && start_rise) |=> (dout_oe_o && !dout_o)); // R2
    AST_MSB_AT_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_READ) |-> (dout_oe_o && !busy_o && dout_o == result_w[DATA_W-1])); // R5
    AST_CONV_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV) |=> (state_q == ST_CONV || state_q == ST_READ)); // R10
    AST_RELEASE_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dout_oe_o) |-> $past(shift_done)); // R7

endmodule

// File: tb/autoshdn_sar_if_tb_top.sv
module autoshdn_sar_if_tb_top;
    localparam int CLK_DIV    = 63;
    localparam int CONV_TICKS = 14;
    localparam int GAP_CYC    = 32;
    localparam int CONV_CYC   = CLK_DIV * CONV_TICKS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic sclk = 1'b0;
    logic [9:0] sample_a = '0;
    logic [9:0] sample_b = '0;
    logic se_dout, se_oe, se_busy;
    logic df_dout, df_oe, df_busy;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    autoshdn_sar_if #(.CLK_DIV(CLK_DIV), .CONV_TICKS(CONV_TICKS), .GAP_CYC(GAP_CYC),
                      .DIFF_INPUT(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .sclk_i(sclk),
        .sample_a_i(sample_a), .sample_b_i(sample_b),
        .dout_o(se_dout), .dout_oe_o(se_oe), .busy_o(se_busy)
    );

    autoshdn_sar_if #(.CLK_DIV(CLK_DIV), .CONV_TICKS(CONV_TICKS), .GAP_CYC(GAP_CYC),
                      .DIFF_INPUT(1)) dut_d_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .sclk_i(sclk),
        .sample_a_i(sample_a), .sample_b_i(sample_b),
        .dout_o(df_dout), .dout_oe_o(df_oe), .busy_o(df_busy)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [9:0] diff_exp(input logic [9:0] a, input logic [9:0] b,
                                            input bit bip);
        int d = int'(a) - int'(b);
        if (!bip) return (d < 0) ? 10'd0 : 10'(d);
        if (d > 511) d = 511;
        if (d < -512) d = -512;
        return 10'(d);
    endfunction

    // both instances idle or released
    task automatic chk_idle(input string req);
        chk(se_oe == 1'b0, req, "se oe idle", se_oe, 0);
        chk(df_oe == 1'b0, req, "diff oe idle", df_oe, 0);
        chk(se_busy == 1'b0, req, "se busy idle", se_busy, 0);
    endtask

    // busy window after the conversion's start fall; inputs scrambled after hold (R9)
    task automatic conv_wait(input int elapsed, input logic [9:0] a, input logic [9:0] b);
        sample_a = ~a;
        sample_b = ~b;
        cyc(CONV_CYC - 8 - elapsed);
        chk(se_busy == 1'b1, "R5", "busy before end", se_busy, 1);
        chk(df_busy == 1'b1, "R5", "diff busy before end", df_busy, 1);
        cyc(16);
        chk(se_busy == 1'b0, "R5", "busy after end", se_busy, 0);
        chk(se_oe == 1'b1, "R5", "oe at MSB", se_oe, 1);
    endtask

    task automatic start_seq(input bit dbl, input logic [9:0] a, input logic [9:0] b);
        sample_a = a;
        sample_b = b;
        start = 1'b1;
        cyc(6);
        chk(se_oe && !se_dout, "R2", "track drives low", {se_oe, se_dout}, 2);
        chk(df_oe && !df_dout, "R2", "diff track drives low", {df_oe, df_dout}, 2);
        cyc(94);
        if (dbl) begin
            start = 1'b0;
            cyc(10);
            start = 1'b1;
            cyc(100);
        end
        start = 1'b0;
        cyc(8);
        chk(se_busy == 1'b1, "R5", "busy after fall", se_busy, 1);
        conv_wait(8, a, b);
    endtask

    task automatic read_frame(input int nbits, input logic [9:0] v_se,
                              input logic [9:0] v_df, input string req);
        logic [11:0] f_se = {v_se, 2'b00};
        logic [11:0] f_df = {v_df, 2'b00};
        for (int i = 0; i < nbits; i++) begin
            chk(se_dout == f_se[11-i], (i >= 10) ? "R6" : req, "se bit", se_dout, f_se[11-i]);
            chk(df_dout == f_df[11-i], (i >= 10) ? "R6" : req, "diff bit", df_dout, f_df[11-i]);
            sclk = 1'b1;
            cyc(8);
            if (i < 11) begin
                chk(se_dout == f_se[11-i], "R6", "held over rise", se_dout, f_se[11-i]);
            end
            sclk = 1'b0;
            cyc(8);
        end
        if (nbits == 12) begin
            chk(se_oe == 1'b0, "R7", "released after frame", se_oe, 0);
            chk(df_oe == 1'b0, "R7", "diff released after frame", df_oe, 0);
        end
    endtask

    task automatic t_reset();
        chk_idle("R1");
    endtask

    task automatic t_single();
        start_seq(1'b0, 10'h2A5, 10'h0F3);
        read_frame(12, 10'h2A5, diff_exp(10'h2A5, 10'h0F3, 1'b0), "R3");
        chk_idle("R1");
    endtask

    task automatic t_double();
        start_seq(1'b1, 10'h100, 10'h3C0);
        read_frame(12, 10'h3C0, diff_exp(10'h100, 10'h3C0, 1'b1), "R4");
    endtask

    task automatic t_partial();
        start_seq(1'b0, 10'h155, 10'h2AA);
        read_frame(5, 10'h155, diff_exp(10'h155, 10'h2AA, 1'b0), "R3");
        start_seq(1'b0, 10'h3FF, 10'h000);
        read_frame(12, 10'h000, diff_exp(10'h3FF, 10'h000, 1'b1), "R8");
    endtask

    task automatic t_after_full();
        start_seq(1'b0, 10'h3FF, 10'h001);
        read_frame(12, 10'h3FF, diff_exp(10'h3FF, 10'h001, 1'b0), "R3");
        start_seq(1'b0, 10'h010, 10'h020);
        read_frame(12, 10'h010, diff_exp(10'h010, 10'h020, 1'b0), "R9");
    endtask

    task automatic t_long_gap();
        sample_a = 10'h0AB;
        sample_b = 10'h003;
        start = 1'b1;
        cyc(100);
        start = 1'b0;
        cyc(8);
        chk(se_busy == 1'b1, "R5", "busy after fall", se_busy, 1);
        sample_a = 10'h0AB ^ 10'h3FF;
        sample_b = 10'h003 ^ 10'h3FF;
        cyc(50);
        start = 1'b1;
        cyc(30);
        chk(se_busy == 1'b1, "R10", "busy kept on late rise", se_busy, 1);
        chk(df_busy == 1'b1, "R10", "diff busy kept on late rise", df_busy, 1);
        start = 1'b0;
        conv_wait(88, 10'h0AB, 10'h003);
        read_frame(12, 10'h0AB, diff_exp(10'h0AB, 10'h003, 1'b0), "R4");
    endtask

    task automatic t_bipolar_mid();
        start_seq(1'b1, 10'h050, 10'h080);
        read_frame(12, 10'h080, diff_exp(10'h050, 10'h080, 1'b1), "R9");
        chk_idle("R1");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cyc(10);
        rst_n = 1'b1;
        cyc(5);
        t_reset();
        t_single();
        t_double();
        t_partial();
        t_after_full();
        t_long_gap();
        t_bipolar_mid();
        cyc(10);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule